// File: doc/BRIEF.md
# SPI-Controlled Eight-Bit Parallel Port Expander

This block is an SPI slave that owns one eight-bit bidirectional parallel port. The port is described by two registers: a data register that the pins drive, and a direction register whose set bits turn the matching pins into outputs. A host selects the block by pulling chip-enable low. The SCK level seen at that moment fixes the clock polarity for the whole transaction. The first byte is a control byte, and every byte after it is a data byte.

The control byte carries a two-bit identity that must match the strap inputs, a register select, a read/write direction, two format bits that have no effect here, and a two-bit compare-mode selection. While the control byte shifts in, the block shifts out a status byte. That status byte carries a sticky condition flag, which watched input-pin events set. A read then streams the selected register for as long as chip-enable stays low. A write returns the old register contents while the new byte arrives, and after that byte it releases MISO.

The SPI inputs are expected to be synchronous to `clk`, for example through a synchronizer outside this block. SCK must run at least four times slower than `clk`. MISO is delivered as a value plus an output-enable, so that a pad can build the tri-state driver.

Top module: `spi_port_expander`

## Requirements
- R1: Bytes are eight bits, most significant bit first, with one latch edge of SCK per bit; only one of status load, byte load and shift acts on the transmit register in any clock cycle.
- R2: The SCK level sampled when chip-enable falls sets the polarity. Idle low latches MOSI on rising SCK and shifts MISO on falling SCK. Idle high does the opposite. The first MISO bit is valid before the first latch edge.
- R3: Control byte fields: bits 7:6 identity, bit 5 register select (0 data, 1 direction), bit 4 direction (0 read, 1 write), bits 1:0 compare mode.
- R4: During the control byte, MISO carries a status byte. Bit 7 is the condition flag, bits 1:0 are the compare mode in force before this control byte, and bits 6:2 are zero.
- R5: On a read, each following byte returns the selected register, repeated while chip-enable stays low. A data-register read returns the register bit for output pins and the live pin level for input pins.
- R6: On a write, the raw old register value shifts out during the data byte. The new value is stored on the eighth latch edge and shows on the pins one clock later. MISO output-enable then drops, and further bytes are ignored.
- R7: If bits 7:6 differ from `idStrap`, MISO output-enable drops after the control byte until chip-enable rises, and no register, mode or flag changes.
- R8: `misoOe` is low while chip-enable is high and is raised only by a chip-enable fall.
- R9: `pinOut` equals the data register and `pinOe` equals the direction register. Both reset to 0x00.
- R10: Compare modes: 0 = any input pin changes, 1 = any input pin rises, 2 = any input pin falls, 3 = all input pins equal their data-register bits (at least one input pin). Output pins never cause an event.
- R11: The condition flag is sticky. It clears at the end of an identity-matching control byte whose status reported it as 1. An event in that same cycle sets it again.
- R12: Control bits 3:2 have no effect; a write with them set stores the byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| ceN | input | 1 | Active-low chip-enable |
| sck | input | 1 | Serial clock, synchronous to clk |
| mosi | input | 1 | Serial data from host |
| idStrap | input | 2 | Identity the control byte must match |
| pinIn | input | 8 | Live port pin levels |
| miso | output | 1 | Serial data to host |
| misoOe | output | 1 | Drive enable for miso |
| pinOut | output | 8 | Values driven onto the port pins |
| pinOe | output | 8 | Per-pin output enable |

## Verification
Transactions are run at both SCK polarities, as writes, as streamed reads and as identity mismatches. The polarity runs check that the latch and shift edges swap with the idle level. The write-then-read runs separate the raw old value of the data register from its live mixed read value. Pin patterns are stepped through rises, falls, changes on output pins only, and equality with the data register under each compare mode. This shows that each mode reacts only to its own event and that the flag clears only after it has been reported.

// File: rtl/pxp_pkg.sv
`timescale 1ns/1ps
package pxp_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int ID_W   = 2;
  localparam int MODE_W = 2;
  // control byte field positions (decoded by the control FSM)
  localparam int ID_HI  = 7;
  localparam int ID_LO  = 6;
  localparam int RS_BIT = 5;
  localparam int RW_BIT = 4;

  typedef enum logic [MODE_W-1:0] {
    CMP_ANY  = 2'd0,
    CMP_RISE = 2'd1,
    CMP_FALL = 2'd2,
    CMP_EQ   = 2'd3
  } cmpMode_e;

  typedef struct packed {
    logic              startTx;
    logic              loadTx;
    logic              loadLive;
    logic              regSel;
    logic              shiftTx;
    logic              wrEn;
    logic              setMode;
    logic              clrFlag;
    logic [BYTE_W-1:0] byteIn;
  } strobe_t;
endpackage

// File: rtl/pxp_ctrl.sv
`timescale 1ns/1ps
module pxp_ctrl
  import pxp_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            ceN,
  input  logic            sck,
  input  logic            mosi,
  input  logic [ID_W-1:0] idStrap,
  output strobe_t         stb,
  output logic            misoOe
);
  typedef enum logic [2:0] {PH_IDLE, PH_CTRL, PH_READ, PH_WRITE, PH_HOLD} phase_e;

  phase_e            phase;
  logic              sckQ, ceNQ, cpol, rsQ;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-2:0] rxShift;

  logic ceFall, active, sckRise, sckFall, latchEdge, shiftEdge, byteDone, idMatch;
  logic [BYTE_W-1:0] byteIn;

  assign ceFall    = ceNQ & ~ceN;
  assign active    = ~ceN & ~ceNQ;
  assign sckRise   = sck & ~sckQ;
  assign sckFall   = ~sck & sckQ;
  assign latchEdge = active & (cpol ? sckFall : sckRise);
  assign shiftEdge = active & (cpol ? sckRise : sckFall);
  assign byteDone  = latchEdge && (bitCnt == CNT_W'(BYTE_W-1));
  assign byteIn    = {rxShift, mosi};
  assign idMatch   = (byteIn[ID_HI:ID_LO] == idStrap);

  always_comb begin
    stb          = '0;
    stb.byteIn   = byteIn;
    stb.regSel   = (phase == PH_CTRL) ? byteIn[RS_BIT] : rsQ;
    stb.startTx  = ceFall;
    stb.shiftTx  = shiftEdge && (phase != PH_IDLE);
    if (byteDone) begin
      unique case (phase)
        PH_CTRL: if (idMatch) begin
          stb.setMode  = 1'b1;
          stb.clrFlag  = 1'b1;
          stb.loadTx   = 1'b1;
          stb.loadLive = ~byteIn[RW_BIT];
        end
        PH_READ: begin
          stb.loadTx   = 1'b1;
          stb.loadLive = 1'b1;
        end
        PH_WRITE: stb.wrEn = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ    <= 1'b0;
      ceNQ    <= 1'b1;
      cpol    <= 1'b0;
      rsQ     <= 1'b0;
      phase   <= PH_IDLE;
      bitCnt  <= '0;
      rxShift <= '0;
      misoOe  <= 1'b0;
    end else begin
      sckQ <= sck;
      ceNQ <= ceN;
      if (ceN) begin
        phase  <= PH_IDLE;
        misoOe <= 1'b0;
        bitCnt <= '0;
      end else if (ceFall) begin
        phase  <= PH_CTRL;
        cpol   <= sck;
        bitCnt <= '0;
        misoOe <= 1'b1;
      end else if (latchEdge) begin
        rxShift <= byteIn[BYTE_W-2:0];
        bitCnt  <= byteDone ? '0 : bitCnt + 1'b1;
        if (byteDone) begin
          unique case (phase)
            PH_CTRL: begin
              if (idMatch) begin
                rsQ   <= byteIn[RS_BIT];
                phase <= byteIn[RW_BIT] ? PH_WRITE : PH_READ;
              end else begin
                phase  <= PH_HOLD;
                misoOe <= 1'b0;
              end
            end
            PH_WRITE: begin
              phase  <= PH_HOLD;
              misoOe <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pxp_datapath.sv
`timescale 1ns/1ps
module pxp_datapath
  import pxp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] pinIn,
  output logic [BYTE_W-1:0] dataReg,
  output logic [BYTE_W-1:0] dirReg,
  output logic              miso
);
  logic [BYTE_W-1:0] pinQ, pinPrev, inMask, chgBit, riseBit, fallBit, liveVal, selVal, statusByte;
  logic [BYTE_W:0]   txShift;
  logic              seeded, flag, snapFlag, eqHit, hit, cmpEvent;
  cmpMode_e          cmpMode;

  assign inMask = ~dirReg;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_pinEvt
    assign chgBit[i]  = inMask[i] & (pinQ[i] ^ pinPrev[i]);
    assign riseBit[i] = inMask[i] & pinQ[i] & ~pinPrev[i];
    assign fallBit[i] = inMask[i] & ~pinQ[i] & pinPrev[i];
    assign liveVal[i] = dirReg[i] ? dataReg[i] : pinQ[i];
  end

  assign eqHit = (|inMask) && ((pinQ & inMask) == (dataReg & inMask));

  always_comb begin
    unique case (cmpMode)
      CMP_ANY:  hit = |chgBit;
      CMP_RISE: hit = |riseBit;
      CMP_FALL: hit = |fallBit;
      default:  hit = eqHit;
    endcase
  end

  assign cmpEvent   = seeded & hit;
  assign selVal     = stb.regSel ? dirReg : (stb.loadLive ? liveVal : dataReg);
  assign statusByte = {flag, {(BYTE_W-1-MODE_W){1'b0}}, cmpMode};
  assign miso       = txShift[BYTE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinQ     <= '0;
      pinPrev  <= '0;
      seeded   <= 1'b0;
      flag     <= 1'b0;
      snapFlag <= 1'b0;
      cmpMode  <= CMP_ANY;
      txShift  <= '0;
      dataReg  <= '0;
      dirReg   <= '0;
    end else begin
      pinQ <= pinIn;
      if (!seeded) begin
        pinPrev <= pinIn;
        seeded  <= 1'b1;
      end else begin
        pinPrev <= pinQ;
      end

      flag <= cmpEvent | (flag & ~(stb.clrFlag & snapFlag));
      if (stb.startTx) snapFlag <= flag;
      if (stb.setMode) cmpMode <= cmpMode_e'(stb.byteIn[MODE_W-1:0]);

      if (stb.startTx)      txShift <= {statusByte, 1'b0};
      else if (stb.loadTx)  txShift <= {txShift[BYTE_W], selVal};
      else if (stb.shiftTx) txShift <= {txShift[BYTE_W-1:0], 1'b0};

      if (stb.wrEn) begin
        if (stb.regSel) dirReg  <= stb.byteIn;
        else            dataReg <= stb.byteIn;
      end
    end
  end
endmodule

// File: rtl/spi_port_expander.sv
`timescale 1ns/1ps
module spi_port_expander
  import pxp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              sck,
  input  logic              mosi,
  input  logic [ID_W-1:0]   idStrap,
  input  logic [BYTE_W-1:0] pinIn,
  output logic              miso,
  output logic              misoOe,
  output logic [BYTE_W-1:0] pinOut,
  output logic [BYTE_W-1:0] pinOe
);
  strobe_t stb;

  pxp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .sck(sck), .mosi(mosi),
    .idStrap(idStrap), .stb(stb), .misoOe(misoOe)
  );

  pxp_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pinIn(pinIn),
    .dataReg(pinOut), .dirReg(pinOe), .miso(miso)
  );
endmodule

// File: rtl/spi_port_expander_chk.sv
`timescale 1ns/1ps
module spi_port_expander_chk
  import pxp_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              misoOe,
  input logic [BYTE_W-1:0] pinOut,
  input logic [BYTE_W-1:0] pinOe,
  input logic              startTx,
  input logic              loadTx,
  input logic              shiftTx,
  input logic              wrEn
);
  p_oe_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> !misoOe);

  p_oe_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(misoOe) |-> ($past(ceN, 2) && !$past(ceN)));

  p_pins_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> ($stable(pinOut) && $stable(pinOe)));

  p_hiz_after_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !misoOe);

  p_one_action_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startTx, loadTx, shiftTx}));
endmodule

bind spi_port_expander spi_port_expander_chk u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .misoOe(misoOe),
  .pinOut(pinOut), .pinOe(pinOe),
  .startTx(stb.startTx), .loadTx(stb.loadTx),
  .shiftTx(stb.shiftTx), .wrEn(stb.wrEn)
);

// File: tb/spi_port_expander_bench.sv
`timescale 1ns/1ps
module spi_port_expander_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic [1:0] idStrap = 2'b10;
  logic [7:0] pinIn = 8'h00;
  logic miso, misoOe;
  logic [7:0] pinOut, pinOe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic idle = 1'b0;

  always #2.5 clk = ~clk;

  spi_port_expander u_spi_port_expander (
    .clk(clk), .rstN(rstN), .ceN(ceN), .sck(sck), .mosi(mosi),
    .idStrap(idStrap), .pinIn(pinIn), .miso(miso), .misoOe(misoOe),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startTx(input logic pol);
    idle = pol;
    sck  = pol;
    waitClk(3);
    ceN = 1'b0;
    waitClk(4);
  endtask

  task automatic endTx();
    waitClk(4);
    ceN = 1'b1;
    waitClk(6);
  endtask

  // one byte: leading edge (away from idle) latches, trailing edge shifts
  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oeAll);
    oeAll = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      waitClk(4);
      rx[i] = miso;
      oeAll = oeAll & misoOe;
      sck = ~idle;
      waitClk(4);
      sck = idle;
    end
  endtask

  task automatic t_reset();
    chk("R9 reset pinOut", pinOut, 8'h00);
    chk("R9 reset pinOe", pinOe, 8'h00);
    chk("R8 reset misoOe", {7'd0, misoOe}, 8'h00);
  endtask

  task automatic t_write_dir();
    logic [7:0] rx; logic oe;
    startTx(1'b0);
    chk("R8 oe after ce fall", {7'd0, misoOe}, 8'h01);
    xfer(8'hB0, rx, oe);                 // id 10, dir reg, write, mode 0
    chk("R4 R2 status idle-low", rx, 8'h00);
    xfer(8'h0F, rx, oe);
    chk("R6 old dir value", rx, 8'h00);
    chk("R6 R9 pinOe after write", pinOe, 8'h0F);
    xfer(8'hFF, rx, oe);
    chk("R6 oe low after write byte", {7'd0, oe}, 8'h00);
    chk("R6 extra byte ignored", pinOe, 8'h0F);
    endTx();
    chk("R8 oe low ce high", {7'd0, misoOe}, 8'h00);
  endtask

  task automatic t_write_data_fmt();
    logic [7:0] rx; logic oe;
    startTx(1'b1);
    xfer(8'h9C, rx, oe);                 // data reg, write, format 11, mode 0
    chk("R2 R4 status idle-high", rx, 8'h00);
    xfer(8'hA5, rx, oe);
    chk("R6 old data value", rx, 8'h00);
    chk("R12 R3 plain store", pinOut, 8'hA5);
    endTx();
  endtask

  task automatic t_read_stream();
    logic [7:0] rx; logic oe;
    pinIn = 8'h3C;                       // input nibble changes: mode 0 event
    waitClk(6);
    startTx(1'b0);
    xfer(8'h81, rx, oe);                 // read data, mode 1
    chk("R4 R11 flag reported", rx, 8'h80);
    for (int b = 0; b < 3; b++) begin
      xfer(8'h00, rx, oe);
      chk("R5 R1 streamed mixed read", rx, 8'h35);
    end
    chk("R5 oe held during read", {7'd0, oe}, 8'h01);
    endTx();
    startTx(1'b1);
    xfer(8'hA1, rx, oe);                 // read dir, mode 1
    chk("R11 flag cleared", rx, 8'h01);
    xfer(8'h00, rx, oe);
    chk("R5 R3 dir read", rx, 8'h0F);
    endTx();
  endtask

  task automatic statusOf(input logic [7:0] ctrl, output logic [7:0] st);
    logic [7:0] rx; logic oe;
    startTx(1'b0);
    xfer(ctrl, st, oe);
    xfer(8'h00, rx, oe);
    endTx();
  endtask

  task automatic t_compare();
    logic [7:0] st;
    pinIn = 8'h7C; waitClk(6);           // bit6 rises in mode 1
    statusOf(8'hA2, st);
    chk("R10 rise mode", st, 8'h81);
    pinIn = 8'hFC; waitClk(6);           // rise ignored in mode 2
    statusOf(8'hA2, st);
    chk("R10 rise ignored fall mode", st, 8'h02);
    pinIn = 8'h7C; waitClk(6);           // bit7 falls
    statusOf(8'hA3, st);
    chk("R10 fall mode", st, 8'h82);
    pinIn = 8'hA0; waitClk(6);           // inputs equal data upper nibble
    pinIn = 8'h20; waitClk(6);
    statusOf(8'hA0, st);
    chk("R10 equal mode", st, 8'h83);
    pinIn = 8'h2F; waitClk(6);           // only output pins change
    statusOf(8'hA0, st);
    chk("R10 output pins excluded", st, 8'h00);
  endtask

  task automatic t_id_mismatch();
    logic [7:0] rx; logic oe;
    startTx(1'b0);
    xfer(8'h73, rx, oe);                 // id 01, dir write, mode 3
    xfer(8'hFF, rx, oe);
    chk("R7 oe low after mismatch", {7'd0, oe}, 8'h00);
    endTx();
    chk("R7 dir unchanged", pinOe, 8'h0F);
    startTx(1'b0);
    xfer(8'hA0, rx, oe);
    chk("R7 mode unchanged", rx, 8'h00);
    xfer(8'h00, rx, oe);
    chk("R7 dir read", rx, 8'h0F);
    endTx();
  endtask

  initial begin
    waitClk(4);
    t_reset();
    rstN = 1'b1;
    waitClk(4);
    t_write_dir();
    t_write_data_fmt();
    t_read_stream();
    t_compare();
    t_id_mismatch();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule